// File: doc/BRIEF.md
# Floating-Point Status and Exception Tracker

This block keeps the floating-point status/control word of a processor core and turns the exception outcome of each finished floating-point operation into flag, cause and trap activity. Software writes the word through a write port; the write is masked so that undefined bit positions always read back as zero. The arithmetic datapath reports each finished operation with a valid strobe, five raw exception bits, and, for compares, the relation it found. The block also decodes two controls from the word for the datapath: round-toward-zero and denormal flush.

An arithmetic operation, or a compare whose result is unordered, replaces the flag field with the new exception bits. It also ORs them into the sticky cause field. If that operation raised at least one exception and the updated cause overlaps the enable field, a trap request with a fixed exception code pulses for one cycle. A compare with an ordered result leaves the word alone and instead reports a new value for the condition bit.

Word layout: rounding mode in bits 1:0, flags in 6:2, enables in 11:7, cause in 17:12, denormal flush at 18, bank select at 21. Within the flag, enable and cause fields, the exception order from the lowest bit upward is inexact, underflow, overflow, divide-by-zero, invalid. The exception input uses the same order: bit 0 inexact up to bit 4 invalid.

Top module: `fpsr_tracker`

## Requirements
- R1: After reset the status word reads 0x00000000, and trap_req and tbit_we are low.
- R2: A write stores wr_data AND 0x0027FFFF, which is visible on csr_q the cycle after wr_en.
- R3: round_to_zero is 1 exactly when bits 1:0 of the word equal 01. The values 00, 10 and 11 give 0, which selects round-to-nearest-even.
- R4: flush_denorm follows bit 18 of the word.
- R5: A status-updating operation replaces the flag field (bits 6:2) with exc, so that flags from earlier operations are cleared even when exc is zero.
- R6: A status-updating operation ORs exc into cause bits 16:12. Cause bits stay set until software rewrites them.
- R7: A status-updating operation with nonzero exc, whose updated cause ANDed with enables (bits 11:7) is nonzero, produces trap_req high for exactly one cycle, the cycle after the operation, with trap_code 0x120. Otherwise trap_code is 0.
- R8: An operation with exc equal to zero never raises trap_req, even when cause and enables already overlap.
- R9: A compare whose relation (cmp_rel: 0 less, 1 equal, 2 greater, 3 unordered) is ordered leaves the word unchanged. One cycle later it pulses tbit_we, with tbit_val = (relation is greater) when cmp_gt is 1, and (relation is equal) when cmp_gt is 0.
- R10: An unordered compare updates the status as an arithmetic operation does (R5 to R7) and does not pulse tbit_we.
- R11: A write in the same cycle as a status-updating operation wins: the word takes the masked write data and no trap is raised.
- R12: Operations never alter the rounding, enable, denormal, bank or cause-bit-17 fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 32 | Status word write data |
| op_valid | input | 1 | A floating-point operation finished this cycle |
| op_is_cmp | input | 1 | The finished operation is a compare |
| cmp_gt | input | 1 | Compare predicate: 1 greater-than, 0 equal |
| cmp_rel | input | 2 | Compare relation: 0 less, 1 equal, 2 greater, 3 unordered |
| exc | input | 5 | Raw exceptions: bit 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid |
| csr_q | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Exception code, 0x120 while trap_req is high |
| round_to_zero | output | 1 | Datapath rounding select |
| flush_denorm | output | 1 | Datapath denormal flush enable |
| tbit_we | output | 1 | Condition bit update strobe |
| tbit_val | output | 1 | New condition bit value |

## Verification
A wrong flag or cause bit inside the block shows on csr_q one cycle after the operation that produced it. A wrong sticky cause bit can stay hidden until a later operation with a nonzero exception meets a matching enable; at that point it turns into a missing or spurious trap_req. The directed scenarios therefore chain operations so that earlier cause bits decide later traps. They also check the pulse in the cycle after the operation and again in the cycle after that.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int CSR_W    = 32;
    localparam int N_EXC    = 5;
    localparam int RM_LO    = 0;
    localparam int RM_W     = 2;
    localparam int FLAG_LO  = 2;
    localparam int EN_LO    = 7;
    localparam int CAUSE_LO = 12;
    localparam int CAUSE_W  = 6;
    localparam int DN_BIT   = 18;
    localparam int BANK_BIT = 21;
    localparam int CODE_W   = 12;
    localparam logic [CODE_W-1:0] TRAP_CODE = 12'h120;
    localparam logic [RM_W-1:0]   RM_ZERO   = 2'b01;

    function automatic logic [CSR_W-1:0] build_mask();
        logic [CSR_W-1:0] m;
        m = '0;
        for (int i = 0; i < RM_W; i++)    m[RM_LO + i]    = 1'b1;
        for (int i = 0; i < N_EXC; i++)   m[FLAG_LO + i]  = 1'b1;
        for (int i = 0; i < N_EXC; i++)   m[EN_LO + i]    = 1'b1;
        for (int i = 0; i < CAUSE_W; i++) m[CAUSE_LO + i] = 1'b1;
        m[DN_BIT]   = 1'b1;
        m[BANK_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [CSR_W-1:0] CSR_MASK = build_mask();

    typedef enum logic [1:0] {
        REL_LESS    = 2'd0,
        REL_EQUAL   = 2'd1,
        REL_GREATER = 2'd2,
        REL_UNORD   = 2'd3
    } cmp_rel_e;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_STATUS = 2'd1,
        EV_TBIT   = 2'd2
    } event_e;

endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
    import fpsr_pkg::*;
(
    input  logic       op_valid,
    input  logic       op_is_cmp,
    input  logic       cmp_gt,
    input  logic [1:0] cmp_rel,
    output event_e     kind,
    output logic       tbit_next
);
    cmp_rel_e rel;
    assign rel = cmp_rel_e'(cmp_rel);

    always_comb begin
        kind      = EV_NONE;
        tbit_next = 1'b0;
        if (op_valid) begin
            if (!op_is_cmp) begin
                kind = EV_STATUS;
            end else begin
                unique case (rel)
                    REL_UNORD:   kind = EV_STATUS;
                    REL_EQUAL:   begin kind = EV_TBIT; tbit_next = !cmp_gt; end
                    REL_GREATER: begin kind = EV_TBIT; tbit_next = cmp_gt;  end
                    REL_LESS:    begin kind = EV_TBIT; tbit_next = 1'b0;    end
                endcase
            end
        end
    end
endmodule

// File: rtl/fpsr_status_next.sv
module fpsr_status_next
    import fpsr_pkg::*;
(
    input  logic [CSR_W-1:0] csr_cur,
    input  logic [N_EXC-1:0] exc,
    output logic [CSR_W-1:0] csr_upd,
    output logic             trap_hit
);
    logic [N_EXC-1:0] cause_new;
    logic [N_EXC-1:0] enables;

    assign enables   = csr_cur[EN_LO +: N_EXC];
    assign cause_new = csr_cur[CAUSE_LO +: N_EXC] | exc;

    always_comb begin
        csr_upd                     = csr_cur;
        csr_upd[FLAG_LO +: N_EXC]   = exc;
        csr_upd[CAUSE_LO +: N_EXC]  = cause_new;
    end

    assign trap_hit = (|exc) && (|(cause_new & enables));
endmodule

// File: rtl/fpsr_mode_decode.sv
module fpsr_mode_decode
    import fpsr_pkg::*;
(
    input  logic [CSR_W-1:0] csr_cur,
    output logic             round_to_zero,
    output logic             flush_denorm
);
    assign round_to_zero = (csr_cur[RM_LO +: RM_W] == RM_ZERO);
    assign flush_denorm  = csr_cur[DN_BIT];
endmodule

// File: rtl/fpsr_tracker.sv
module fpsr_tracker
    import fpsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        op_valid,
    input  logic        op_is_cmp,
    input  logic        cmp_gt,
    input  logic [1:0]  cmp_rel,
    input  logic [4:0]  exc,
    output logic [31:0] csr_q,
    output logic        trap_req,
    output logic [11:0] trap_code,
    output logic        round_to_zero,
    output logic        flush_denorm,
    output logic        tbit_we,
    output logic        tbit_val
);
    event_e           kind;
    logic             tbit_next;
    logic [CSR_W-1:0] csr_upd;
    logic             trap_hit;
    logic [CSR_W-1:0] csr_r;
    logic             trap_r;
    logic             tbit_we_r;
    logic             tbit_val_r;

    fpsr_classify u_classify (
        .op_valid  (op_valid),
        .op_is_cmp (op_is_cmp),
        .cmp_gt    (cmp_gt),
        .cmp_rel   (cmp_rel),
        .kind      (kind),
        .tbit_next (tbit_next)
    );

    fpsr_status_next u_next (
        .csr_cur  (csr_r),
        .exc      (exc),
        .csr_upd  (csr_upd),
        .trap_hit (trap_hit)
    );

    fpsr_mode_decode u_mode (
        .csr_cur       (csr_r),
        .round_to_zero (round_to_zero),
        .flush_denorm  (flush_denorm)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_r      <= '0;
            trap_r     <= 1'b0;
            tbit_we_r  <= 1'b0;
            tbit_val_r <= 1'b0;
        end else begin
            trap_r    <= 1'b0;
            tbit_we_r <= 1'b0;
            if (wr_en) begin
                csr_r <= wr_data & CSR_MASK;
            end else if (kind == EV_STATUS) begin
                csr_r  <= csr_upd;
                trap_r <= trap_hit;
            end
            if (kind == EV_TBIT) begin
                tbit_we_r  <= 1'b1;
                tbit_val_r <= tbit_next;
            end
        end
    end

    assign csr_q     = csr_r;
    assign trap_req  = trap_r;
    assign trap_code = trap_r ? TRAP_CODE : '0;
    assign tbit_we   = tbit_we_r;
    assign tbit_val  = tbit_val_r;
endmodule

// File: rtl/fpsr_tracker_chk.sv
module fpsr_tracker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        op_valid,
    input logic        op_is_cmp,
    input logic        cmp_gt,
    input logic [1:0]  cmp_rel,
    input logic [4:0]  exc,
    input logic [31:0] csr_q,
    input logic        trap_req,
    input logic [11:0] trap_code,
    input logic        round_to_zero,
    input logic        flush_denorm,
    input logic        tbit_we,
    input logic        tbit_val
);
    localparam logic [31:0] MASK = 32'h0027FFFF;

    p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q & ~MASK) == 32'h0);

    p_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (csr_q == ($past(wr_data) & MASK)) && !trap_req);

    p_rtz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        round_to_zero == (csr_q[1:0] == 2'b01));

    p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_denorm == csr_q[18]);

    p_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && !wr_en && (!op_is_cmp || cmp_rel == 2'd3))
        |-> csr_q[6:2] == $past(exc));

    p_trap_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_valid && !wr_en && (exc != 5'd0)));

    p_trap_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_code == 12'h120);

    p_cmp_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_is_cmp && cmp_rel != 2'd3 && !wr_en) |-> $stable(csr_q));

    p_tbit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tbit_we |-> $past(op_valid && op_is_cmp && cmp_rel != 2'd3)
                    && tbit_val == $past(cmp_gt ? (cmp_rel == 2'd2) : (cmp_rel == 2'd1)));
endmodule

bind fpsr_tracker fpsr_tracker_chk u_chk (.*);

// File: tb/fpsr_tracker_test.sv
module fpsr_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_valid = 1'b0;
    logic        op_is_cmp = 1'b0;
    logic        cmp_gt = 1'b0;
    logic [1:0]  cmp_rel = 2'd0;
    logic [4:0]  exc = '0;
    logic [31:0] csr_q;
    logic        trap_req;
    logic [11:0] trap_code;
    logic        round_to_zero;
    logic        flush_denorm;
    logic        tbit_we;
    logic        tbit_val;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fpsr_tracker uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_op(input logic is_cmp, input logic gt, input logic [1:0] rel,
                         input logic [4:0] e);
        @(negedge clk);
        op_valid = 1'b1; op_is_cmp = is_cmp; cmp_gt = gt; cmp_rel = rel; exc = e;
        @(negedge clk);
        op_valid = 1'b0; op_is_cmp = 1'b0; cmp_gt = 1'b0; cmp_rel = 2'd0; exc = '0;
    endtask

    task automatic t_reset();
        check("R1 csr", csr_q, 32'h0);
        check("R1 trap", {31'b0, trap_req}, 32'h0);
        check("R1 tbit_we", {31'b0, tbit_we}, 32'h0);
    endtask

    task automatic t_write_mask();
        do_write(32'hFFFF_FFFF);
        check("R2 masked write", csr_q, 32'h0027_FFFF);
        check("R3 rm=11", {31'b0, round_to_zero}, 32'h0);
        check("R4 flush on", {31'b0, flush_denorm}, 32'h1);
    endtask

    task automatic t_round_modes();
        do_write(32'h1);
        check("R3 rm=01", {31'b0, round_to_zero}, 32'h1);
        check("R4 flush off", {31'b0, flush_denorm}, 32'h0);
        do_write(32'h2);
        check("R3 rm=10", {31'b0, round_to_zero}, 32'h0);
        do_write(32'h0);
        check("R3 rm=00", {31'b0, round_to_zero}, 32'h0);
    endtask

    task automatic t_flags_cause();
        do_op(1'b0, 1'b0, 2'd0, 5'b10001);
        check("R5 R6 first op", csr_q, 32'h0001_1044);
        check("R8 no enables no trap", {31'b0, trap_req}, 32'h0);
        do_op(1'b0, 1'b0, 2'd0, 5'b00010);
        check("R5 R6 second op", csr_q, 32'h0001_3008);
        do_op(1'b0, 1'b0, 2'd0, 5'b00000);
        check("R5 flags cleared cause kept", csr_q, 32'h0001_3000);
    endtask

    task automatic t_trap();
        do_write(32'h0000_0400);
        do_op(1'b0, 1'b0, 2'd0, 5'b01000);
        check("R7 csr", csr_q, 32'h0000_8420);
        check("R7 trap", {31'b0, trap_req}, 32'h1);
        check("R7 code", {20'b0, trap_code}, 32'h120);
        @(negedge clk);
        check("R7 single pulse", {31'b0, trap_req}, 32'h0);
        check("R7 code idle", {20'b0, trap_code}, 32'h0);
        do_op(1'b0, 1'b0, 2'd0, 5'b00000);
        check("R8 csr", csr_q, 32'h0000_8400);
        check("R8 no trap", {31'b0, trap_req}, 32'h0);
        do_op(1'b0, 1'b0, 2'd0, 5'b00001);
        check("R7 sticky cause csr", csr_q, 32'h0000_9404);
        check("R7 sticky cause trap", {31'b0, trap_req}, 32'h1);
    endtask

    task automatic t_compare();
        do_op(1'b1, 1'b0, 2'd1, 5'b0);
        check("R9 eq/equal we", {31'b0, tbit_we}, 32'h1);
        check("R9 eq/equal val", {31'b0, tbit_val}, 32'h1);
        check("R9 csr kept", csr_q, 32'h0000_9404);
        check("R9 no trap", {31'b0, trap_req}, 32'h0);
        do_op(1'b1, 1'b1, 2'd0, 5'b0);
        check("R9 gt/less val", {31'b0, tbit_val}, 32'h0);
        do_op(1'b1, 1'b1, 2'd2, 5'b0);
        check("R9 gt/greater val", {31'b0, tbit_val}, 32'h1);
        do_op(1'b1, 1'b0, 2'd2, 5'b0);
        check("R9 eq/greater val", {31'b0, tbit_val}, 32'h0);
        check("R9 csr kept 2", csr_q, 32'h0000_9404);
        @(negedge clk);
        check("R9 we pulse ends", {31'b0, tbit_we}, 32'h0);
    endtask

    task automatic t_unordered();
        do_op(1'b1, 1'b0, 2'd3, 5'b10000);
        check("R10 csr", csr_q, 32'h0001_9440);
        check("R10 trap", {31'b0, trap_req}, 32'h1);
        check("R10 no tbit", {31'b0, tbit_we}, 32'h0);
    endtask

    task automatic t_write_wins();
        do_write(32'h0000_0F80);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h0000_0001;
        op_valid = 1'b1; exc = 5'b11111;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; op_valid = 1'b0; exc = '0;
        check("R11 csr", csr_q, 32'h0000_0001);
        check("R11 no trap", {31'b0, trap_req}, 32'h0);
    endtask

    task automatic t_fields_kept();
        do_write(32'h0024_0F81);
        do_op(1'b0, 1'b0, 2'd0, 5'b00000);
        check("R12 csr unchanged", csr_q, 32'h0024_0F81);
        check("R12 no trap", {31'b0, trap_req}, 32'h0);
        do_op(1'b0, 1'b0, 2'd0, 5'b00100);
        check("R12 fields kept", csr_q, 32'h0024_4F91);
        check("R12 trap", {31'b0, trap_req}, 32'h1);
        check("R12 rm kept", {31'b0, round_to_zero}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_mask();
        t_round_modes();
        t_flags_cause();
        t_trap();
        t_compare();
        t_unordered();
        t_write_wins();
        t_fields_kept();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule